// File: doc/BRIEF.md
# Mixed-Width Segmented Data Cache

This block is a compact two-way set-associative write-back data cache that serves 16-bit and 32-bit loads and stores from a processor pipeline. Every 64-bit line is stored as four 16-bit segments, and each segment has its own write enable. For each access, the width flag and the low address bits decide which segments are active. A halfword access touches one segment. A word access touches an aligned pair of segments. The set mapping and the tag comparison do not depend on the access width. One line can therefore serve as two words or as four halfwords, and mixing the two views is allowed.

A control FSM has four states:

- **IDLE**: waits for a request and latches it.
- **LOOKUP**: compares the tags, then either finishes the access or picks a victim way.
- **WBACK**: writes a dirty victim line to memory.
- **FILL**: loads the requested line from memory.

The transitions are:

- IDLE→LOOKUP on a request.
- LOOKUP→IDLE on a hit or on a misaligned access.
- LOOKUP→WBACK on a miss whose victim line is dirty.
- LOOKUP→FILL on a miss whose victim line is clean or invalid.
- WBACK→FILL when memory acknowledges the writeback.
- FILL→LOOKUP when memory acknowledges the fill. The second lookup then hits.

Top module: `mwc_cache`

## Requirements
- R1: After reset no line is valid, `cpu_ready` and `mem_req` are low, and the first access to any address causes a line fill.
- R2: Byte address bits [2:0] are the offset within the line and bits [6:3] select one of 16 sets. The bits above them form the tag. A fill or writeback presents the line base address, with bits [2:0] zero, on `mem_addr`.
- R3: Halfword k of a line (k = address bits [2:1]) is `mem_rdata` bits [16k+15:16k]. A 16-bit read returns that halfword zero-extended. A 32-bit read at address bit 2 = j returns halfwords 2j+1 and 2j as {high, low}. Exactly one segment is enabled for a 16-bit access and two for a 32-bit access.
- R4: A write hit changes only the enabled segments. The other segments of the line keep their contents, and the line becomes dirty.
- R5: A 16-bit access with address bit 0 set is misaligned, and so is a 32-bit access with bit 1 or bit 0 set. Such an access completes at once with `cpu_ready` and `cpu_error` both high. It causes no memory traffic and leaves the cache contents unchanged.
- R6: A miss whose victim is clean or invalid issues one read request (`mem_we` = 0). The access then completes with the filled data.
- R7: A miss whose victim is valid and dirty first writes back the whole victim line (`mem_we` = 1, victim address), and only after that fills the new line.
- R8: The victim is an invalid way if one exists, with way 0 preferred; otherwise it is the least recently used way. Every hit and every fill marks the way it used as the most recently used.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` stay stable.
- R10: `cpu_ready` is a single-cycle pulse that marks the completion of each accepted request.
- R11: A 16-bit access and a 32-bit access to the same line hit the same cached copy, so data written at one width can be read back at the other width without a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_wdata | input | 32 | Store data (low 16 bits used for a halfword store) |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Access complete pulse |
| cpu_error | output | 1 | Misaligned access, high together with `cpu_ready` |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = writeback, 0 = fill |
| mem_addr | output | ADDR_W | Line base address |
| mem_wdata | output | 64 | Writeback line data |
| mem_rdata | input | 64 | Fill line data, sampled with `mem_ack` |
| mem_ack | input | 1 | Memory transfer done, one cycle |

## Verification
The hardest path to reach is the writeback of a dirty victim, because several conditions must hold together. Both ways of one set must be valid, the line to be evicted must have been written, and the replacement bit must point at that line rather than at its partner. The stimulus first writes a line in set 2 and then reads a second tag in the same set, which fills the other way and makes it the most recent. A third tag in that set then forces the eviction. The bench captures the writeback payload and compares it with its own shadow copy of the line. It then re-reads the evicted address to confirm that the written halfwords survived the round trip through memory.

// File: rtl/mwc_pkg.sv
package mwc_pkg;
    localparam int SEG_W  = 16;
    localparam int SEG_N  = 4;
    localparam int LINE_W = SEG_W * SEG_N;
    localparam int OFF_W  = 3;
    localparam int WAYS   = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FILL
    } cache_state_t;
endpackage

// File: rtl/mwc_seg_decode.sv
module mwc_seg_decode
    import mwc_pkg::*;
(
    input  logic             wide,
    input  logic [OFF_W-1:0] offset,
    output logic [SEG_N-1:0] seg_en,
    output logic             misaligned
);
    always_comb begin
        misaligned = offset[0] | (wide & offset[1]);
        seg_en     = '0;
        if (wide) begin
            seg_en[{offset[2], 1'b0}] = 1'b1;
            seg_en[{offset[2], 1'b1}] = 1'b1;
        end else begin
            seg_en[offset[2:1]] = 1'b1;
        end
    end

    always_comb begin
        assert_seg_onehot_R3: assert (wide || $onehot(seg_en))
            else $error("narrow access must enable exactly one segment");
    end
endmodule

// File: rtl/mwc_data_array.sv
module mwc_data_array
    import mwc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_way,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEG_N-1:0]  wr_seg_en,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int SETS = 1 << IDX_W;

    logic [SEG_W-1:0] seg_rd [WAYS][SEG_N];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        for (genvar k = 0; k < SEG_N; k++) begin : g_seg
            logic [SEG_W-1:0] seg_q [SETS];
            always_ff @(posedge clk) begin
                if (wr_en && (wr_way == 1'(w)) && wr_seg_en[k])
                    seg_q[wr_idx] <= wr_line[k*SEG_W +: SEG_W];
            end
            assign seg_rd[w][k] = seg_q[rd_idx];
        end
    end

    always_comb begin
        for (int k = 0; k < SEG_N; k++)
            rd_line[k*SEG_W +: SEG_W] = seg_rd[rd_way][k];
    end
endmodule

// File: rtl/mwc_tag_store.sv
module mwc_tag_store
    import mwc_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            idx,
    output logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    output logic [WAYS-1:0]             way_valid,
    output logic [WAYS-1:0]             way_dirty,
    output logic                        lru_way,
    input  logic                        fill_en,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic                        mark_dirty,
    input  logic                        touch_en,
    input  logic                        touch_way
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [SETS-1:0]  lru_q;

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx][touch_way] <= fill_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
            lru_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[idx][touch_way] <= 1'b1;
                dirty_q[idx][touch_way] <= 1'b0;
            end
            if (mark_dirty) dirty_q[idx][touch_way] <= 1'b1;
            if (touch_en)   lru_q[idx] <= ~touch_way;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign way_tag[w] = tag_q[idx][w];
    end
    assign way_valid = valid_q[idx];
    assign way_dirty = dirty_q[idx];
    assign lru_way   = lru_q[idx];
endmodule

// File: rtl/mwc_cache.sv
module mwc_cache
    import mwc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wide,
    input  logic              cpu_we,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_ready,
    output logic              cpu_error,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_ack
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    cache_state_t state_q, state_d;

    logic [ADDR_W-1:0] q_addr;
    logic              q_wide, q_we;
    logic [31:0]       q_wdata;

    // Request latch, loaded when the FSM accepts a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr <= '0; q_wide <= 1'b0; q_we <= 1'b0; q_wdata <= '0;
        end else if (state_q == ST_IDLE && cpu_req) begin
            q_addr <= cpu_addr; q_wide <= cpu_wide; q_we <= cpu_we; q_wdata <= cpu_wdata;
        end
    end

    logic [TAG_W-1:0] q_tag;
    logic [IDX_W-1:0] q_idx;
    assign q_tag = q_addr[ADDR_W-1 -: TAG_W];
    assign q_idx = q_addr[OFF_W +: IDX_W];

    logic [SEG_N-1:0] seg_en;
    logic             misaligned;

    mwc_seg_decode i_dec (
        .wide(q_wide), .offset(q_addr[OFF_W-1:0]),
        .seg_en(seg_en), .misaligned(misaligned)
    );

    logic [WAYS-1:0][TAG_W-1:0] way_tag;
    logic [WAYS-1:0] way_valid, way_dirty;
    logic lru_way, fill_en, mark_dirty, touch_en, touch_way;

    mwc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
        .clk(clk), .rst_n(rst_n), .idx(q_idx),
        .way_tag(way_tag), .way_valid(way_valid), .way_dirty(way_dirty), .lru_way(lru_way),
        .fill_en(fill_en), .fill_tag(q_tag), .mark_dirty(mark_dirty),
        .touch_en(touch_en), .touch_way(touch_way)
    );

    logic [WAYS-1:0] hit_vec;
    logic hit, hit_way, victim_way, victim_dirty;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == q_tag);
    end
    assign hit          = |hit_vec;
    assign hit_way      = hit_vec[1];
    assign victim_way   = !way_valid[0] ? 1'b0 : (!way_valid[1] ? 1'b1 : lru_way);
    assign victim_dirty = way_valid[victim_way] && way_dirty[victim_way];

    logic              rd_way, arr_wr, wr_way;
    logic [SEG_N-1:0]  wr_seg_en;
    logic [LINE_W-1:0] rd_line, wr_line, wdata_rep;

    assign rd_way    = (state_q == ST_LOOKUP) ? hit_way : victim_way;
    assign wdata_rep = q_wide ? {2{q_wdata}} : {4{q_wdata[15:0]}};

    mwc_data_array #(.IDX_W(IDX_W)) i_data (
        .clk(clk), .rd_idx(q_idx), .rd_way(rd_way), .rd_line(rd_line),
        .wr_en(arr_wr), .wr_way(wr_way), .wr_idx(q_idx),
        .wr_seg_en(wr_seg_en), .wr_line(wr_line)
    );

    always_comb begin
        if (q_wide) cpu_rdata = rd_line[{q_addr[2], 5'b0} +: 32];
        else        cpu_rdata = {16'b0, rd_line[{q_addr[2:1], 4'b0} +: 16]};
    end

    assign mem_wdata = rd_line;
    assign mem_addr  = (state_q == ST_WBACK) ? {way_tag[victim_way], q_idx, 3'b000}
                                             : {q_tag, q_idx, 3'b000};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        cpu_error  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        arr_wr     = 1'b0;
        fill_en    = 1'b0;
        mark_dirty = 1'b0;
        touch_en   = 1'b0;
        touch_way  = hit_way;
        wr_way     = hit_way;
        wr_seg_en  = seg_en;
        wr_line    = wdata_rep;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (misaligned) begin
                    cpu_ready = 1'b1;
                    cpu_error = 1'b1;
                    state_d   = ST_IDLE;
                end else if (hit) begin
                    cpu_ready = 1'b1;
                    touch_en  = 1'b1;
                    if (q_we) begin
                        arr_wr     = 1'b1;
                        mark_dirty = 1'b1;
                    end
                    state_d = ST_IDLE;
                end else if (victim_dirty) begin
                    state_d = ST_WBACK;
                end else begin
                    state_d = ST_FILL;
                end
            end
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) state_d = ST_FILL;
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                wr_way    = victim_way;
                touch_way = victim_way;
                wr_seg_en = '1;
                wr_line   = mem_rdata;
                if (mem_ack) begin
                    arr_wr   = 1'b1;
                    fill_en  = 1'b1;
                    touch_en = 1'b1;
                    state_d  = ST_LOOKUP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    assert_error_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_error |-> (cpu_ready && !mem_req && !arr_wr));

    assert_seg_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && !misaligned) |-> ($countones(seg_en) == (q_wide ? 2 : 1)));

    assert_wback_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && !misaligned && !hit && victim_dirty) |=> (state_q == ST_WBACK));

    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_dirty_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && !misaligned && hit && q_we) |=> way_dirty[$past(hit_way)]);

    assert_fill_hits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_ack) |=> hit);
endmodule

// File: tb/test_mwc_cache.sv
module test_mwc_cache;
    localparam int ADDR_W = 16;
    localparam int LINES  = 1 << (ADDR_W - 3);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cpu_req, cpu_wide, cpu_we;
    logic [ADDR_W-1:0] cpu_addr;
    logic [31:0]       cpu_wdata, cpu_rdata;
    logic              cpu_ready, cpu_error;
    logic              mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [63:0]       mem_wdata, mem_rdata;

    mwc_cache #(.ADDR_W(ADDR_W), .IDX_W(4)) i_mwc_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_wide(cpu_wide), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_error(cpu_error),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    initial forever #4 clk = ~clk;

    logic [63:0] mem_model [LINES];
    logic [63:0] ref_model [LINES];
    int n_checks = 0, n_fail = 0;
    int fills = 0, wbacks = 0, hold_viol = 0, pulse_bad = 0;
    logic [ADDR_W-1:0] last_fill_addr, last_wb_addr;
    logic [63:0] last_wb_data;

    function automatic logic [63:0] init_line(int l);
        logic [63:0] v;
        for (int k = 0; k < 4; k++) v[k*16 +: 16] = 16'(l*4 + k) ^ 16'h5A3C;
        return v;
    endfunction

    function automatic logic [31:0] exp_read(logic [ADDR_W-1:0] a, logic wide);
        logic [63:0] ln;
        ln = ref_model[a[ADDR_W-1:3]];
        if (wide) return ln[{a[2], 5'b0} +: 32];
        return {16'b0, ln[{a[2:1], 4'b0} +: 16]};
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory responder: two cycles of latency, one-cycle ack
    initial begin
        logic [ADDR_W-1:0] a;
        logic w;
        logic [63:0] d;
        mem_ack = 1'b0;
        mem_rdata = '0;
        for (int i = 0; i < LINES; i++) begin
            mem_model[i] = init_line(i);
            ref_model[i] = init_line(i);
        end
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req && rst_n) begin
                a = mem_addr; w = mem_we; d = mem_wdata;
                repeat (2) begin
                    @(negedge clk);
                    if (!mem_req || mem_addr !== a || mem_we !== w || (w && mem_wdata !== d)) hold_viol++;
                end
                if (w) begin
                    mem_model[a[ADDR_W-1:3]] = d;
                    wbacks++; last_wb_addr = a; last_wb_data = d;
                end else begin
                    mem_rdata = mem_model[a[ADDR_W-1:3]];
                    fills++; last_fill_addr = a;
                end
                mem_ack = 1'b1;
            end
        end
    end

    task automatic access(input logic [ADDR_W-1:0] a, input logic wide, input logic we,
                          input logic [31:0] wd, output logic [31:0] rd, output logic err);
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a; cpu_wide = wide; cpu_we = we; cpu_wdata = wd;
        do @(negedge clk); while (!cpu_ready);
        rd = cpu_rdata; err = cpu_error;
        cpu_req = 1'b0;
        if (we && !err) begin
            if (wide) ref_model[a[ADDR_W-1:3]][{a[2], 5'b0} +: 32] = wd;
            else      ref_model[a[ADDR_W-1:3]][{a[2:1], 4'b0} +: 16] = wd[15:0];
        end
        @(negedge clk);
        if (cpu_ready) pulse_bad++;
    endtask

    task automatic read_check(input logic [ADDR_W-1:0] a, input logic wide, input string req);
        logic [31:0] rd, ex;
        logic err;
        ex = exp_read(a, wide);
        access(a, wide, 1'b0, 32'h0, rd, err);
        check(rd === ex && !err, req, $sformatf("read %h w%0d", a, wide), {32'h0, rd}, {32'h0, ex});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cpu_ready === 1'b0 && mem_req === 1'b0, "R1", "idle after reset",
              {62'h0, cpu_ready, mem_req}, 64'h0);
    endtask

    task automatic t_cold_miss();
        int f0;
        f0 = fills;
        read_check(16'h0012, 1'b0, "R3");
        check(fills == f0 + 1, "R6", "cold miss fill count", 64'(fills), 64'(f0 + 1));
        check(last_fill_addr === 16'h0010, "R2", "fill line base", {48'h0, last_fill_addr}, 64'h10);
    endtask

    task automatic t_width_mix();
        int f0;
        f0 = fills;
        read_check(16'h0014, 1'b1, "R3");
        read_check(16'h0016, 1'b0, "R11");
        read_check(16'h0010, 1'b0, "R11");
        check(fills == f0, "R11", "no fill across widths", 64'(fills), 64'(f0));
    endtask

    task automatic t_write_hit();
        logic [31:0] rd;
        logic err;
        int f0;
        f0 = fills;
        access(16'h0012, 1'b0, 1'b1, 32'hFFFF_BEEF, rd, err);
        read_check(16'h0010, 1'b1, "R4");
        access(16'h0014, 1'b1, 1'b1, 32'h1234_5678, rd, err);
        read_check(16'h0014, 1'b0, "R4");
        read_check(16'h0016, 1'b0, "R11");
        check(fills == f0, "R4", "write hit no fill", 64'(fills), 64'(f0));
    endtask

    task automatic t_misalign();
        logic [31:0] rd;
        logic err;
        int f0, w0;
        f0 = fills; w0 = wbacks;
        access(16'h0012, 1'b1, 1'b0, 32'h0, rd, err);
        check(err === 1'b1, "R5", "32-bit at bit1 error", {63'h0, err}, 64'h1);
        access(16'h0011, 1'b0, 1'b1, 32'h0000_DEAD, rd, err);
        check(err === 1'b1, "R5", "16-bit odd error", {63'h0, err}, 64'h1);
        access(16'h0016, 1'b1, 1'b1, 32'hCAFE_CAFE, rd, err);
        check(err === 1'b1, "R5", "32-bit store misaligned error", {63'h0, err}, 64'h1);
        check(fills == f0 && wbacks == w0, "R5", "no memory traffic",
              64'(fills + wbacks), 64'(f0 + w0));
        read_check(16'h0010, 1'b1, "R5");
        read_check(16'h0014, 1'b1, "R5");
    endtask

    task automatic t_evict();
        int f0, w0;
        f0 = fills; w0 = wbacks;
        read_check(16'h0090, 1'b0, "R8");
        check(fills == f0 + 1 && wbacks == w0, "R8", "invalid way filled", 64'(fills), 64'(f0 + 1));
        read_check(16'h0112, 1'b0, "R7");
        check(wbacks == w0 + 1, "R7", "dirty victim written back", 64'(wbacks), 64'(w0 + 1));
        check(last_wb_addr === 16'h0010, "R2", "writeback line base", {48'h0, last_wb_addr}, 64'h10);
        check(last_wb_data === ref_model[2], "R7", "writeback payload", last_wb_data, ref_model[2]);
        check(last_fill_addr === 16'h0110, "R7", "fill after writeback", {48'h0, last_fill_addr}, 64'h110);
        f0 = fills; w0 = wbacks;
        read_check(16'h0094, 1'b1, "R8");
        check(fills == f0, "R8", "recent line kept", 64'(fills), 64'(f0));
        read_check(16'h0012, 1'b0, "R7");
        read_check(16'h0014, 1'b1, "R6");
        check(fills == f0 + 1 && wbacks == w0, "R6", "clean LRU victim refill",
              64'(wbacks), 64'(w0));
        read_check(16'h0096, 1'b0, "R8");
        check(fills == f0 + 1, "R8", "other way still resident", 64'(fills), 64'(f0 + 1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_req = 1'b0; cpu_addr = '0; cpu_wide = 1'b0; cpu_we = 1'b0; cpu_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cold_miss();
        t_width_mix();
        t_write_hit();
        t_misalign();
        t_evict();
        check(pulse_bad == 0, "R10", "ready single pulse", 64'(pulse_bad), 64'h0);
        check(hold_viol == 0, "R9", "memory request held", 64'(hold_viol), 64'h0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule